// File: doc/BRIEF.md
# I2C Slave Receiver with Status Flags

This block is an I2C slave receiver that an 8-bit host controls through four small registers. Both bus lines are sampled through a short synchronizer, and START and STOP conditions are found on the synchronized lines. The first byte after a START is compared with a programmable 7-bit own address. On a match the block acknowledges that byte and every following data byte, and it places each data byte in a data latch.

Four status flags follow the bus: a started flag, a buffer-full flag, an address-match flag and a word-address tag. Each flag has its own rule for being cleared. Two enable bits decide which flags pull the active-low level interrupt. A control bit turns the whole slave on or off. Another control bit routes the slave to one of two SDA/SCL pin pairs, and the pair that is not chosen is never driven.

Top module: `i2c_flag_slave`

Host register map (`host_addr`): 0 = control, 1 = own address (bits 6:0), 2 = status, 3 = data latch. Control bits: bit0 enable, bit1 pair select, bit2 buffer interrupt enable, bit3 match interrupt enable. Status bits: bit0 started, bit1 buffer full, bit2 address match, bit3 word-address tag.

## Requirements
- R1: After reset, every register and flag reads 0, `irq_n` is 1 and neither `sda_a_oe` nor `sda_b_oe` is asserted.
- R2: While control bit0 is 0, bus traffic changes no flag and the slave never drives SDA.
- R3: Control bit1 = 1 connects the slave to pair A and 0 connects it to pair B. Traffic on the pair that is not selected is ignored, and that pair's SDA enable stays 0.
- R4: Status bit0 is set by a START and cleared by a STOP.
- R5: When the first byte after a START carries the own address in bits 7:1 and a 0 (write) in bit 0, the slave acknowledges it and sets status bit2. Any other first byte, including the own address with the read bit set, is not acknowledged and leaves status bit2 unchanged.
- R6: Status bit2 is cleared only by a host write to register 2 with bit2 = 0. A write with bit2 = 1 leaves it set.
- R7: Each data byte after a matching address is acknowledged, is stored in register 3, and sets status bit1.
- R8: A host read of register 3 clears status bit1.
- R9: Status bit3 is 1 when the byte in register 3 was the first data byte after the address, and 0 for any later byte.
- R10: After a repeated START and a matching address, the next data byte is tagged as a word address again.
- R11: `irq_n` is 0 exactly when (status bit1 and control bit2) or (status bit2 and control bit3) holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational on host_addr |
| scl_a_i | input | 1 | SCL level of pin pair A |
| sda_a_i | input | 1 | SDA level of pin pair A |
| sda_a_oe | output | 1 | Pull SDA of pair A low |
| scl_b_i | input | 1 | SCL level of pin pair B |
| sda_b_i | input | 1 | SDA level of pin pair B |
| sda_b_oe | output | 1 | Pull SDA of pair B low |
| irq_n | output | 1 | Active-low level interrupt |

## Verification
The bench uses the default two-stage synchronizer and a bus bit phase of eight clocks. With these values the slave's sampling lag of about three cycles falls well inside every SCL phase. Acknowledge timing can then be observed on the open-drain line, as can single-pair routing and every clearing rule. The own address is set to 0x5A. The bench also sends a non-matching address and the matching address with the read bit set, so the compare is exercised on both sides.

// File: rtl/i2c_flag_slave_pkg.sv
package i2c_flag_slave_pkg;

    localparam int DW = 8;
    localparam int AW = 7;

    // status bit positions
    localparam int ST_START = 0;
    localparam int ST_BUF   = 1;
    localparam int ST_MATCH = 2;
    localparam int ST_TAG   = 3;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_OWN  = 2'd1,
        REG_STAT = 2'd2,
        REG_DATA = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_AACK, PH_AHOLD,
        PH_DATA, PH_DACK, PH_DHOLD, PH_SKIP
    } phase_e;

    // control register, bit0 = en
    typedef struct packed {
        logic mie;
        logic bie;
        logic sel;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic          start;
        logic          stop;
        logic          hit;
        logic          byte_vld;
        logic          first;
        logic [DW-1:0] data;
    } rx_ev_t;

    function automatic logic addr_hit(input logic [DW-1:0] b, input logic [AW-1:0] own);
        return (b[DW-1:1] == own) && !b[0];
    endfunction

endpackage

// File: rtl/i2c_flag_slave_sync.sv
module i2c_flag_slave_sync
    import i2c_flag_slave_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_raw,
    input  logic    sda_raw,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_q, sda_q, scl_s, sda_s;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain[0] <= 1'b1;
                    sda_chain[0] <= 1'b1;
                end else begin
                    scl_chain[0] <= scl_raw;
                    sda_chain[0] <= sda_raw;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain[i] <= 1'b1;
                    sda_chain[i] <= 1'b1;
                end else begin
                    scl_chain[i] <= scl_chain[i-1];
                    sda_chain[i] <= sda_chain[i-1];
                end
            end
        end
    end

    assign scl_s = scl_chain[STAGES-1];
    assign sda_s = sda_chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.start = scl_s && scl_q && sda_q && !sda_s;
        ev.stop  = scl_s && scl_q && !sda_q && sda_s;
        ev.rise  = scl_s && !scl_q;
        ev.fall  = !scl_s && scl_q;
        ev.sda   = sda_s;
    end

endmodule

// File: rtl/i2c_flag_slave_fsm.sv
module i2c_flag_slave_fsm
    import i2c_flag_slave_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [AW-1:0] own,
    input  bus_ev_t       ev,
    output rx_ev_t        rx,
    output logic          sda_drive
);
    phase_e        state;
    logic [2:0]    bitcnt;
    logic [DW-1:0] shreg;
    logic [DW-1:0] nxt_byte;
    logic          first_pend;

    assign nxt_byte = {shreg[DW-2:0], ev.sda};

    always_ff @(posedge clk) begin
        rx <= '0;
        if (rst) begin
            state      <= PH_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            first_pend <= 1'b0;
            sda_drive  <= 1'b0;
        end else if (!en) begin
            state      <= PH_IDLE;
            sda_drive  <= 1'b0;
            first_pend <= 1'b0;
        end else if (ev.start) begin
            state      <= PH_ADDR;
            bitcnt     <= '0;
            sda_drive  <= 1'b0;
            first_pend <= 1'b0;
            rx.start   <= 1'b1;
        end else if (ev.stop) begin
            state      <= PH_IDLE;
            sda_drive  <= 1'b0;
            first_pend <= 1'b0;
            rx.stop    <= 1'b1;
        end else begin
            case (state)
                PH_ADDR: if (ev.rise) begin
                    shreg  <= nxt_byte;
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) begin
                        if (addr_hit(nxt_byte, own)) begin
                            state      <= PH_AACK;
                            rx.hit     <= 1'b1;
                            first_pend <= 1'b1;
                        end else begin
                            state <= PH_SKIP;
                        end
                    end
                end
                PH_AACK: if (ev.fall) begin
                    sda_drive <= 1'b1;
                    state     <= PH_AHOLD;
                end
                PH_AHOLD, PH_DHOLD: if (ev.fall) begin
                    sda_drive <= 1'b0;
                    state     <= PH_DATA;
                    bitcnt    <= '0;
                end
                PH_DATA: if (ev.rise) begin
                    shreg  <= nxt_byte;
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) begin
                        rx.byte_vld <= 1'b1;
                        rx.data     <= nxt_byte;
                        rx.first    <= first_pend;
                        first_pend  <= 1'b0;
                        state       <= PH_DACK;
                    end
                end
                PH_DACK: if (ev.fall) begin
                    sda_drive <= 1'b1;
                    state     <= PH_DHOLD;
                end
                default: ;
            endcase
        end
    end

    // R2
    off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state == PH_IDLE && !sda_drive));

    // R5
    drive_phase_chk: assert property (@(posedge clk) disable iff (rst)
        sda_drive |-> (state == PH_AHOLD || state == PH_DHOLD));

endmodule

// File: rtl/i2c_flag_slave_regs.sv
module i2c_flag_slave_regs
    import i2c_flag_slave_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          rd,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    input  rx_ev_t        rx,
    output logic [DW-1:0] rdata,
    output ctrl_t         ctrl,
    output logic [AW-1:0] own,
    output logic          irq_n
);
    logic          started, buf_full, matched, tag;
    logic [DW-1:0] data_q;
    reg_sel_e      sel_e;
    logic          wr_stat, rd_data;

    assign sel_e   = reg_sel_e'(addr);
    assign wr_stat = wr && (sel_e == REG_STAT);
    assign rd_data = rd && (sel_e == REG_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            own      <= '0;
            started  <= 1'b0;
            buf_full <= 1'b0;
            matched  <= 1'b0;
            tag      <= 1'b0;
            data_q   <= '0;
        end else begin
            if (wr && sel_e == REG_CTRL) ctrl <= ctrl_t'(wdata[3:0]);
            if (wr && sel_e == REG_OWN)  own  <= wdata[AW-1:0];
            if (wr_stat && !wdata[ST_MATCH]) matched <= 1'b0;
            if (rx.hit) matched <= 1'b1;
            if (rx.start)     started <= 1'b1;
            else if (rx.stop) started <= 1'b0;
            if (rd_data) buf_full <= 1'b0;
            if (rx.byte_vld) begin
                buf_full <= 1'b1;
                data_q   <= rx.data;
                tag      <= rx.first;
            end
        end
    end

    always_comb begin
        case (sel_e)
            REG_CTRL: rdata = {4'b0, ctrl};
            REG_OWN:  rdata = {1'b0, own};
            REG_STAT: rdata = {4'b0, tag, matched, buf_full, started};
            default:  rdata = data_q;
        endcase
    end

    assign irq_n = !((buf_full && ctrl.bie) || (matched && ctrl.mie));

    // R4
    started_set_chk: assert property (@(posedge clk) disable iff (rst)
        rx.start |=> started);

    // R4
    started_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (rx.stop && !rx.start) |=> !started);

    // R6
    match_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (matched && wr_stat && wdata[ST_MATCH]) |=> matched);

    // R8
    buf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !rx.byte_vld) |=> !buf_full);

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.bie && !ctrl.mie) |-> irq_n);

endmodule

// File: rtl/i2c_flag_slave.sv
module i2c_flag_slave
    import i2c_flag_slave_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [1:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       scl_a_i,
    input  logic       sda_a_i,
    output logic       sda_a_oe,
    input  logic       scl_b_i,
    input  logic       sda_b_i,
    output logic       sda_b_oe,
    output logic       irq_n
);
    ctrl_t         ctrl;
    logic [AW-1:0] own;
    bus_ev_t       ev;
    rx_ev_t        rx;
    logic          drive;
    logic          scl_mux, sda_mux;

    assign scl_mux = ctrl.sel ? scl_a_i : scl_b_i;
    assign sda_mux = ctrl.sel ? sda_a_i : sda_b_i;

    i2c_flag_slave_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (host_wr),
        .rd    (host_rd),
        .addr  (host_addr),
        .wdata (host_wdata),
        .rx    (rx),
        .rdata (host_rdata),
        .ctrl  (ctrl),
        .own   (own),
        .irq_n (irq_n)
    );

    i2c_flag_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_mux),
        .sda_raw (sda_mux),
        .ev      (ev)
    );

    i2c_flag_slave_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl.en),
        .own       (own),
        .ev        (ev),
        .rx        (rx),
        .sda_drive (drive)
    );

    assign sda_a_oe = drive && ctrl.sel;
    assign sda_b_oe = drive && !ctrl.sel;

endmodule

// File: tb/i2c_flag_slave_test.sv
module i2c_flag_slave_test;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       sda_a_oe, sda_b_oe, irq_n;
    logic       m_scl = 1'b1, m_sda = 1'b1, use_b = 1'b0;
    wire        scl_a = use_b ? 1'b1 : m_scl;
    wire        scl_b = use_b ? m_scl : 1'b1;
    wire        sda_a = (use_b ? 1'b1 : m_sda) & !sda_a_oe;
    wire        sda_b = (use_b ? m_sda : 1'b1) & !sda_b_oe;
    wire        line  = use_b ? sda_b : sda_a;

    int checks = 0, fails = 0;
    bit done = 0;
    // reference model
    bit e_st, e_buf, e_match, e_tag, m_en, m_sel, m_bie, m_mie;
    logic [7:0] e_data;

    always #5 clk = ~clk;

    i2c_flag_slave uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .scl_a_i(scl_a), .sda_a_i(sda_a), .sda_a_oe(sda_a_oe),
        .scl_b_i(scl_b), .sda_b_i(sda_b), .sda_b_oe(sda_b_oe), .irq_n(irq_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_stat();
        return {e_tag, e_match, e_buf, e_st};
    endfunction

    function automatic int exp_irq();
        return !((e_buf && m_bie) || (e_match && m_mie));
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    // compare model against ports on every clock of a quiet window
    task automatic settle(input int n);
        repeat (n) begin
            @(negedge clk);
            check("R11 irq_n", irq_n, exp_irq());
            if (m_sel) check("R3 pair B undriven", sda_b_oe, 0);
            else       check("R3 pair A undriven", sda_a_oe, 0);
        end
    endtask

    task automatic hw_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hw_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic set_ctrl(input bit en, input bit sel, input bit bie, input bit mie);
        m_en = en; m_sel = sel; m_bie = bie; m_mie = mie;
        hw_write(2'd0, {4'b0, mie, bie, sel, en});
    endtask

    task automatic stat_is(input string req);
        logic [7:0] d;
        hw_read(2'd2, d);
        check(req, d, exp_stat());
    endtask

    task automatic data_is(input string req);
        logic [7:0] d;
        hw_read(2'd3, d);
        check(req, d, e_data);
        e_buf = 0;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_clk(H);
        m_scl = 1'b1; wait_clk(H);
        m_sda = 1'b0; wait_clk(H);
        m_scl = 1'b0; wait_clk(H);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_clk(H);
        m_scl = 1'b1; wait_clk(H);
        m_sda = 1'b1; wait_clk(H);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wait_clk(H);
            m_scl = 1'b1; wait_clk(H);
            m_scl = 1'b0;
        end
        m_sda = 1'b1; wait_clk(H);
        m_scl = 1'b1; wait_clk(H / 2);
        acked = (line == 1'b0);
        wait_clk(H / 2);
        m_scl = 1'b0;
    endtask

    initial begin
        wait_clk(150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] d;
        wait_clk(4);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        check("R1 irq_n", irq_n, 1);
        check("R1 oe a", sda_a_oe, 0);
        check("R1 oe b", sda_b_oe, 0);
        stat_is("R1 status");
        hw_read(2'd0, d); check("R1 ctrl", d, 0);
        hw_read(2'd1, d); check("R1 own", d, 0);
        settle(4);

        hw_write(2'd1, 8'h5A);
        set_ctrl(1, 1, 1, 1);

        bus_start(); e_st = 1;
        settle(2); stat_is("R4 started set");
        put_byte(8'hB4, ack); check("R5 address ack", ack, 1);
        e_match = 1; settle(2); stat_is("R5 match flag");

        put_byte(8'h3C, ack); check("R7 data ack", ack, 1);
        e_buf = 1; e_tag = 1; e_data = 8'h3C;
        settle(2); stat_is("R9 first byte tagged");
        data_is("R7 data latch");
        settle(2); stat_is("R8 read clears buffer");

        put_byte(8'hA5, ack); check("R7 second ack", ack, 1);
        e_buf = 1; e_tag = 0; e_data = 8'hA5;
        settle(2); stat_is("R9 later byte untagged");
        data_is("R7 second data");

        hw_write(2'd2, 8'h04);
        settle(2); stat_is("R6 write one keeps match");
        hw_write(2'd2, 8'h00); e_match = 0;
        settle(2); stat_is("R6 write zero clears match");

        // R10 repeated start
        bus_start();
        put_byte(8'hB4, ack); check("R10 readdress ack", ack, 1);
        e_match = 1;
        put_byte(8'h77, ack);
        e_buf = 1; e_tag = 1; e_data = 8'h77;
        settle(2); stat_is("R10 retagged after repeated start");
        data_is("R10 data");
        put_byte(8'h10, ack);
        e_buf = 1; e_tag = 0; e_data = 8'h10;
        settle(2); stat_is("R9 tag drops");
        data_is("R7 data 10");

        bus_stop(); e_st = 0;
        settle(2); stat_is("R4 stop clears started");
        hw_write(2'd2, 8'h00); e_match = 0;

        // R11 gating
        set_ctrl(1, 1, 0, 0);
        bus_start(); put_byte(8'hB4, ack); put_byte(8'h11, ack); bus_stop();
        e_match = 1; e_buf = 1; e_tag = 1; e_data = 8'h11;
        settle(4); stat_is("R11 flags set with gates off");
        set_ctrl(1, 1, 1, 0);
        settle(4);
        data_is("R7 data 11");
        settle(2);
        set_ctrl(1, 1, 0, 1);
        settle(4);
        hw_write(2'd2, 8'h00); e_match = 0;
        settle(2);
        set_ctrl(1, 1, 1, 1);

        // R5 negative cases
        bus_start(); e_st = 1;
        put_byte(8'h22, ack); check("R5 wrong address no ack", ack, 0);
        put_byte(8'h55, ack); check("R5 no data ack", ack, 0);
        bus_stop(); e_st = 0;
        settle(2); stat_is("R5 no flags on mismatch");
        bus_start(); e_st = 1;
        put_byte(8'hB5, ack); check("R5 read bit no ack", ack, 0);
        bus_stop(); e_st = 0;
        settle(2); stat_is("R5 read bit no match");

        // R2 disabled
        set_ctrl(0, 1, 1, 1);
        bus_start();
        settle(2); stat_is("R2 start ignored");
        put_byte(8'hB4, ack); check("R2 no ack", ack, 0);
        put_byte(8'h99, ack); check("R2 no data ack", ack, 0);
        bus_stop();
        settle(2); stat_is("R2 flags untouched");

        // R3 pair B
        set_ctrl(1, 0, 1, 1);
        use_b = 1'b1;
        bus_start(); e_st = 1;
        put_byte(8'hB4, ack); check("R3 pair B ack", ack, 1);
        put_byte(8'h42, ack); check("R3 pair B data ack", ack, 1);
        e_match = 1; e_buf = 1; e_tag = 1; e_data = 8'h42;
        bus_stop(); e_st = 0;
        settle(2); stat_is("R3 pair B flags");
        data_is("R3 pair B data");
        hw_write(2'd2, 8'h00); e_match = 0;
        use_b = 1'b0;
        bus_start();
        put_byte(8'hB4, ack); check("R3 pair A ignored", ack, 0);
        bus_stop();
        settle(2); stat_is("R3 pair A no flags");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule